// File: doc/BRIEF.md
# Two-Way Command Mailbox

This block is the only path between two processor buses, called side A and side B. Each side sends the other a message made of two bytes: first a command byte, then a data byte. The mailbox keeps one two-byte slot for each direction, so both sides can send at the same moment without clashing.

Once the data byte of a message has landed, the receiving side sees a mail-waiting flag. When the receiver fetches the data byte, that flag drops. In the same clock edge, a mail-taken flag rises on the sender's side. Each side has a status word that shows the following:

- whether mail is waiting for it,
- whether its own last message has been taken,
- whether it tried to write over a message the other side had not yet collected.

Both buses run on one common clock. Each side has its own address, read strobe, write strobe and data lines. The reset input is asynchronous and active-low, and its release is synchronised to the clock.

Top module: `duplex_mailbox`

## Requirements
- R1: While reset is held and after it is released, every flag is 0, the read-data outputs are 0, and a status read returns 0.
- R2: A write to address 1 (data byte) by the sender raises the receiver's mail-waiting output on the next clock. A write to address 0 (command byte) alone does not raise it.
- R3: A read is registered. A read at address 0 returns the incoming command byte and a read at address 1 returns the incoming data byte. The value appears on the read-data output one clock after the strobe and holds until the next read.
- R4: A read of address 1 while mail is waiting clears the reader's mail-waiting flag. In the same edge it sets the sender's mail-taken flag.
- R5: The sender's mail-taken flag clears when that sender posts a new data byte.
- R6: A write to address 0 or 1 while the sender's outgoing message is still waiting is rejected and leaves the slot unchanged. It also sets that sender's overrun flag.
- R7: The overrun flag is sticky. It clears only when its side writes address 2 with bit 2 set.
- R8: Address 2 is the status word: bit 0 is incoming mail waiting, bit 1 is outgoing mail taken, bit 2 is overrun, and all other bits are 0. Address 3 reads 0, and writes to it are ignored.
- R9: The two directions are independent. Messages sent by both sides in the same cycles are both delivered intact.
- R10: When a post and a collection happen in the same cycle on one direction, the outcome is decided by the flags as they stood before that clock edge.
- R11: A read of address 1 while no mail is waiting changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_addr | input | 2 | Side A register address |
| a_rd | input | 1 | Side A read strobe |
| a_wr | input | 1 | Side A write strobe |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A registered read data |
| a_mail_in | output | 1 | Mail from B is waiting for A |
| a_mail_taken | output | 1 | B has collected A's last message |
| b_addr | input | 2 | Side B register address |
| b_rd | input | 1 | Side B read strobe |
| b_wr | input | 1 | Side B write strobe |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B registered read data |
| b_mail_in | output | 1 | Mail from A is waiting for B |
| b_mail_taken | output | 1 | A has collected B's last message |

## Verification
The hardest case to reach is one edge where a receiver collects the data byte while the sender writes a new one to the same direction. Random traffic seldom lines this up, so a directed step drives both strobes in the same cycle. The bench then checks three things: the write is rejected with overrun, the collection still succeeds, and the other direction is left alone. A behavioural model that works from the pre-edge state runs on every clock, alongside a long stretch of random two-sided traffic in which overlaps of this kind arise many times.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int MB_AW = 2;

  typedef enum logic [MB_AW-1:0] {
    MB_CMD = 2'd0,
    MB_DAT = 2'd1,
    MB_STS = 2'd2,
    MB_RSV = 2'd3
  } mb_addr_e;

  localparam int STS_IN_AVAIL  = 0;
  localparam int STS_OUT_TAKEN = 1;
  localparam int STS_OVERRUN   = 2;
  localparam int STS_BITS      = 3;
endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cmd,
  input  logic          wr_dat,
  input  logic [DW-1:0] wdata,
  input  logic          clr_ovr,
  input  logic          pop,
  output logic [DW-1:0] cmd_q,
  output logic [DW-1:0] dat_q,
  output logic          avail_q,
  output logic          taken_q,
  output logic          ovr_q
);
  logic any_wr, accept, reject, take;
  logic cmd_en, dat_en, flag_en;
  logic avail_d, taken_d, ovr_d;

  always_comb begin
    any_wr  = wr_cmd | wr_dat;
    accept  = any_wr & ~avail_q;
    reject  = any_wr &  avail_q;
    take    = pop & avail_q;
    cmd_en  = accept & wr_cmd;
    dat_en  = accept & wr_dat;
    flag_en = dat_en | take | reject | clr_ovr;

    avail_d = avail_q;
    taken_d = taken_q;
    ovr_d   = ovr_q;
    if (dat_en) begin
      avail_d = 1'b1;
      taken_d = 1'b0;
    end
    if (take) begin
      avail_d = 1'b0;
      taken_d = 1'b1;
    end
    if (reject)       ovr_d = 1'b1;
    else if (clr_ovr) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_en) begin
      dat_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      taken_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else if (flag_en) begin
      avail_q <= avail_d;
      taken_q <= taken_d;
      ovr_q   <= ovr_d;
    end
  end
endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MB_AW-1:0] addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [DW-1:0]    in_cmd,
  input  logic [DW-1:0]    in_dat,
  input  logic             in_avail,
  input  logic             out_taken,
  input  logic             out_ovr,
  input  logic [DW-1:0]    wdata,
  output logic             wr_cmd,
  output logic             wr_dat,
  output logic             clr_ovr,
  output logic             pop,
  output logic [DW-1:0]    rdata
);
  mb_addr_e      sel;
  logic [DW-1:0] rdata_d;
  logic [DW-1:0] rdata_q;

  always_comb begin
    sel     = mb_addr_e'(addr);
    wr_cmd  = wr & (sel == MB_CMD);
    wr_dat  = wr & (sel == MB_DAT);
    clr_ovr = wr & (sel == MB_STS) & wdata[STS_OVERRUN];
    pop     = rd & (sel == MB_DAT);

    rdata_d = '0;
    case (sel)
      MB_CMD: rdata_d = in_cmd;
      MB_DAT: rdata_d = in_dat;
      MB_STS: begin
        rdata_d[STS_IN_AVAIL]  = in_avail;
        rdata_d[STS_OUT_TAKEN] = out_taken;
        rdata_d[STS_OVERRUN]   = out_ovr;
      end
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbox_pkg::*;
#(
  parameter int DW = 8,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MB_AW-1:0] a_addr,
  input  logic             a_rd,
  input  logic             a_wr,
  input  logic [DW-1:0]    a_wdata,
  output logic [DW-1:0]    a_rdata,
  output logic             a_mail_in,
  output logic             a_mail_taken,
  input  logic [MB_AW-1:0] b_addr,
  input  logic             b_rd,
  input  logic             b_wr,
  input  logic [DW-1:0]    b_wdata,
  output logic [DW-1:0]    b_rdata,
  output logic             b_mail_in,
  output logic             b_mail_taken
);
  localparam int NSIDE = 2;

  logic rst_sync_n;

  // Index by side: 0 = A, 1 = B. Direction d carries mail sent by side d.
  logic [NSIDE-1:0][MB_AW-1:0] s_addr;
  logic [NSIDE-1:0]            s_rd, s_wr;
  logic [NSIDE-1:0][DW-1:0]    s_wdata, s_rdata;

  logic [NSIDE-1:0]            d_wr_cmd, d_wr_dat, d_clr_ovr, d_pop;
  logic [NSIDE-1:0][DW-1:0]    d_cmd, d_dat;
  logic [NSIDE-1:0]            d_avail, d_taken, d_ovr;

  assign s_addr[0]  = a_addr;
  assign s_rd[0]    = a_rd;
  assign s_wr[0]    = a_wr;
  assign s_wdata[0] = a_wdata;
  assign s_addr[1]  = b_addr;
  assign s_rd[1]    = b_rd;
  assign s_wr[1]    = b_wr;
  assign s_wdata[1] = b_wdata;

  mbox_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar p = 0; p < NSIDE; p++) begin : g_side
    localparam int IN = NSIDE - 1 - p;

    mbox_channel #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_cmd  (d_wr_cmd[p]),
      .wr_dat  (d_wr_dat[p]),
      .wdata   (s_wdata[p]),
      .clr_ovr (d_clr_ovr[p]),
      .pop     (d_pop[p]),
      .cmd_q   (d_cmd[p]),
      .dat_q   (d_dat[p]),
      .avail_q (d_avail[p]),
      .taken_q (d_taken[p]),
      .ovr_q   (d_ovr[p])
    );

    mbox_port #(.DW(DW)) u_port (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .addr      (s_addr[p]),
      .rd        (s_rd[p]),
      .wr        (s_wr[p]),
      .in_cmd    (d_cmd[IN]),
      .in_dat    (d_dat[IN]),
      .in_avail  (d_avail[IN]),
      .out_taken (d_taken[p]),
      .out_ovr   (d_ovr[p]),
      .wdata     (s_wdata[p]),
      .wr_cmd    (d_wr_cmd[p]),
      .wr_dat    (d_wr_dat[p]),
      .clr_ovr   (d_clr_ovr[p]),
      .pop       (d_pop[IN]),
      .rdata     (s_rdata[p])
    );
  end

  assign a_rdata      = s_rdata[0];
  assign b_rdata      = s_rdata[1];
  assign a_mail_in    = d_avail[1];
  assign b_mail_in    = d_avail[0];
  assign a_mail_taken = d_taken[0];
  assign b_mail_taken = d_taken[1];
endmodule

// File: rtl/duplex_mailbox_chk.sv
module duplex_mailbox_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic [1:0]    a_addr,
  input logic          a_rd,
  input logic          a_wr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic [1:0]    b_addr,
  input logic          b_rd,
  input logic [1:0]    avail,
  input logic [1:0]    taken,
  input logic [1:0]    ovr,
  input logic [DW-1:0] cmd0,
  input logic [DW-1:0] dat0
);
  p_post_sets_avail_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (a_wr && a_addr == 2'd1 && !avail[0]) |=> avail[0]);

  p_avail_cause_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(avail[0]) |-> $past(a_wr && a_addr == 2'd1));

  p_pop_hands_over_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (b_rd && b_addr == 2'd1 && avail[0]) |=> (!avail[0] && taken[0]));

  p_taken_cleared_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (a_wr && a_addr == 2'd1 && !avail[0]) |=> !taken[0]);

  p_reject_keeps_slot_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (a_wr && a_addr != 2'd2 && a_addr != 2'd3 && avail[0])
      |=> (ovr[0] && $stable(cmd0) && $stable(dat0)));

  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovr[0] && !(a_wr && a_addr == 2'd2 && a_wdata[2])) |=> ovr[0]);

  p_status_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (a_rd && a_addr == 2'd2) |=> (a_rdata[DW-1:3] == '0));

  p_empty_read_inert_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (b_rd && b_addr == 2'd1 && !avail[0] && !a_wr) |=> ($stable(avail[0]) && $stable(taken[0])));
endmodule

bind duplex_mailbox duplex_mailbox_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_ni  (rst_sync_n),
  .a_addr  (a_addr),
  .a_rd    (a_rd),
  .a_wr    (a_wr),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .b_addr  (b_addr),
  .b_rd    (b_rd),
  .avail   (d_avail),
  .taken   (d_taken),
  .ovr     (d_ovr),
  .cmd0    (d_cmd[0]),
  .dat0    (d_dat[0])
);

// File: tb/duplex_mailbox_tb.sv
module duplex_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] t_ad [2];
  logic       t_rd [2];
  logic       t_wr [2];
  logic [7:0] t_wd [2];
  logic [7:0] a_rdata, b_rdata;
  logic a_mail_in, a_mail_taken, b_mail_in, b_mail_taken;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;

  // behavioural model, index = sending side (0 = A, 1 = B)
  logic [7:0] m_cmd [2];
  logic [7:0] m_dat [2];
  bit         m_av [2];
  bit         m_tk [2];
  bit         m_ov [2];
  logic [7:0] m_rd [2];

  always #5 clk = ~clk;

  duplex_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr(t_ad[0]), .a_rd(t_rd[0]), .a_wr(t_wr[0]), .a_wdata(t_wd[0]),
    .a_rdata(a_rdata), .a_mail_in(a_mail_in), .a_mail_taken(a_mail_taken),
    .b_addr(t_ad[1]), .b_rd(t_rd[1]), .b_wr(t_wr[1]), .b_wdata(t_wd[1]),
    .b_rdata(b_rdata), .b_mail_in(b_mail_in), .b_mail_taken(b_mail_taken)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update from pre-edge state (R10)
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_cmd[s] = 0; m_dat[s] = 0; m_av[s] = 0; m_tk[s] = 0; m_ov[s] = 0; m_rd[s] = 0;
      end
    end else begin
      logic [7:0] pc [2];
      logic [7:0] pd [2];
      bit pa [2];
      bit pt [2];
      bit po [2];
      for (int s = 0; s < 2; s++) begin
        pc[s] = m_cmd[s]; pd[s] = m_dat[s]; pa[s] = m_av[s]; pt[s] = m_tk[s]; po[s] = m_ov[s];
      end
      for (int p = 0; p < 2; p++) begin
        int i;
        i = 1 - p;
        if (t_wr[p]) begin
          if (t_ad[p] < 2) begin
            if (pa[p]) m_ov[p] = 1;
            else if (t_ad[p] == 0) m_cmd[p] = t_wd[p];
            else begin m_dat[p] = t_wd[p]; m_av[p] = 1; m_tk[p] = 0; end
          end else if (t_ad[p] == 2 && t_wd[p][2]) m_ov[p] = 0;
        end
        if (t_rd[p]) begin
          case (t_ad[p])
            2'd0: m_rd[p] = pc[i];
            2'd1: begin
              m_rd[p] = pd[i];
              if (pa[i]) begin m_av[i] = 0; m_tk[i] = 1; end
            end
            2'd2: m_rd[p] = {5'd0, po[p], pt[p], pa[i]};
            default: m_rd[p] = 8'd0;
          endcase
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      chk(b_mail_in == m_av[0], "R2 b_mail_in", b_mail_in, m_av[0]);
      chk(a_mail_in == m_av[1], "R9 a_mail_in", a_mail_in, m_av[1]);
      chk(a_mail_taken == m_tk[0], "R4 a_mail_taken", a_mail_taken, m_tk[0]);
      chk(b_mail_taken == m_tk[1], "R5 b_mail_taken", b_mail_taken, m_tk[1]);
      chk(a_rdata == m_rd[0], "R3 a_rdata", a_rdata, m_rd[0]);
      chk(b_rdata == m_rd[1], "R3 b_rdata", b_rdata, m_rd[1]);
    end
  end

  // op: 0 idle, 1 read, 2 write
  task automatic step(input int ao, input logic [1:0] aa, input logic [7:0] awd,
                      input int bo, input logic [1:0] ba, input logic [7:0] bwd);
    @(negedge clk);
    t_rd[0] = (ao == 1); t_wr[0] = (ao == 2); t_ad[0] = aa; t_wd[0] = awd;
    t_rd[1] = (bo == 1); t_wr[1] = (bo == 2); t_ad[1] = ba; t_wd[1] = bwd;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin t_rd[s] = 0; t_wr[s] = 0; end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(2_000_000);
    failures++;
    $display("FAIL R9 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 2; s++) begin t_rd[s] = 0; t_wr[s] = 0; t_ad[s] = 0; t_wd[s] = 0; end
    repeat (4) @(negedge clk);
    chk(a_mail_in == 0 && b_mail_in == 0 && a_mail_taken == 0 && b_mail_taken == 0,
        "R1 flags in reset", {a_mail_in, b_mail_in, a_mail_taken, b_mail_taken}, 0);
    chk(a_rdata == 0 && b_rdata == 0, "R1 rdata in reset", {a_rdata, b_rdata}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_on = 1'b1;

    step(1, 2, 0, 1, 2, 0);
    chk(a_rdata == 8'h00 && b_rdata == 8'h00, "R1 status after reset", {a_rdata, b_rdata}, 0);
    step(2, 0, 8'h5A, 0, 0, 0);
    chk(b_mail_in == 0, "R2 command alone", b_mail_in, 0);
    step(2, 1, 8'hC3, 0, 0, 0);
    chk(b_mail_in == 1, "R2 after data byte", b_mail_in, 1);
    step(0, 0, 0, 1, 2, 0);
    chk(b_rdata == 8'h01, "R8 B status mail waiting", b_rdata, 8'h01);
    step(0, 0, 0, 1, 0, 0);
    chk(b_rdata == 8'h5A, "R3 command byte", b_rdata, 8'h5A);
    chk(b_mail_in == 1, "R3 command read keeps flag", b_mail_in, 1);
    step(2, 0, 8'h11, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0);
    chk(a_rdata == 8'h04, "R6 overrun in status", a_rdata, 8'h04);
    step(0, 0, 0, 1, 1, 0);
    chk(b_rdata == 8'hC3, "R6 slot kept after reject", b_rdata, 8'hC3);
    chk(b_mail_in == 0 && a_mail_taken == 1, "R4 handover", {b_mail_in, a_mail_taken}, 2'b01);
    step(0, 0, 0, 1, 1, 0);
    chk(b_mail_in == 0 && a_mail_taken == 1 && b_rdata == 8'hC3, "R11 empty read",
        {b_mail_in, a_mail_taken}, 2'b01);
    step(0, 0, 0, 1, 0, 0);
    chk(b_rdata == 8'h5A, "R6 command kept after reject", b_rdata, 8'h5A);
    step(1, 2, 0, 0, 0, 0);
    chk(a_rdata == 8'h06, "R7 overrun still set", a_rdata, 8'h06);
    step(2, 2, 8'h04, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0);
    chk(a_rdata == 8'h02, "R7 overrun cleared", a_rdata, 8'h02);
    step(2, 3, 8'hFF, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    chk(a_rdata == 8'h00, "R8 reserved address", a_rdata, 0);
    step(2, 0, 8'h21, 2, 0, 8'h84);
    step(2, 1, 8'h22, 2, 1, 8'h85);
    chk(a_mail_in == 1 && b_mail_in == 1, "R9 both directions", {a_mail_in, b_mail_in}, 2'b11);
    chk(a_mail_taken == 0, "R5 taken cleared by new post", a_mail_taken, 0);
    step(2, 1, 8'h99, 1, 1, 0);
    chk(b_rdata == 8'h22 && b_mail_in == 0 && a_mail_taken == 1, "R10 same-cycle pop wins",
        b_rdata, 8'h22);
    step(1, 2, 0, 0, 0, 0);
    chk(a_rdata == 8'h07, "R10 write rejected, overrun", a_rdata, 8'h07);
    step(1, 0, 0, 0, 0, 0);
    chk(a_rdata == 8'h84, "R9 B command", a_rdata, 8'h84);
    step(1, 1, 0, 0, 0, 0);
    chk(a_rdata == 8'h85 && b_mail_taken == 1, "R9 B data", a_rdata, 8'h85);

    // random two-sided traffic, checked each clock against the model
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      for (int s = 0; s < 2; s++) begin
        int r;
        r = $urandom_range(7);
        t_rd[s] = (r == 3 || r == 4);
        t_wr[s] = (r >= 5);
        t_ad[s] = 2'($urandom_range(3));
        t_wd[s] = 8'($urandom);
      end
    end
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin t_rd[s] = 0; t_wr[s] = 0; end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule